// File: doc/BRIEF.md
# Reset and stop-wake policy controller

This controller tracks whether the core is running normally or sitting in a low-power stop state. Each cycle it looks at event pulses from several sources and decides on one action: request a chip reset, enter the external interrupt service routine, or continue execution. It can also report that stop has been released. The sources are an external reset pin, a watchdog timeout, a power-on-reset detector, a low-voltage detector, an external interrupt with its enable status, and two groups of port wake pins.

A static option input selects one of two policy columns. That choice only matters while the controller is stopped. There, the same wake source either leaves stop into an ISR or continue, or leaves stop and forces a full reset. A stop-entry request puts the controller into the stop state. Every action output is a registered pulse that is high for one cycle. When several events fall in one cycle, they are reduced to a single action by a fixed priority.

Top module: `wake_policy_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `in_stop`, `rst_req`, `isr_req`, `cont_req` and `stop_rel` are all 0.
- R2: A `stop_req` pulse while `in_stop` is 0 sets `in_stop` on the next clock edge, unless the same cycle resolves to a reset action. `stop_req` has no effect while `in_stop` is 1.
- R3: An `ev_pin_rst` pulse gives an `rst_req` pulse one cycle later in either state and for either `opt_sel`. When this happens in stop, `stop_rel` stays 0.
- R4: An `ev_wdt` pulse gives a reset when not stopped. While stopped it is ignored: there is no action, and `in_stop` stays 1.
- R5: An `ev_por` pulse gives a `cont_req` when not stopped. While stopped with `opt_sel`=1 it is ignored. While stopped with `opt_sel`=0 it gives `stop_rel` plus `rst_req`.
- R6: An `ev_lvd` pulse gives a reset when not stopped. While stopped with `opt_sel`=1 it gives `stop_rel` plus `rst_req`. While stopped with `opt_sel`=0 it is ignored.
- R7: Outside stop, `ev_xint` gives `isr_req` when `xint_en`=1 and `cont_req` when `xint_en`=0. In stop with `xint_en`=1, it gives `stop_rel` plus `isr_req` for `opt_sel`=1, and `stop_rel` plus `rst_req` for `opt_sel`=0. In stop with `xint_en`=0 it is ignored.
- R8: Any bit of `wake_hi` in stop gives `stop_rel` plus `cont_req` for `opt_sel`=1, and `stop_rel` plus `rst_req` for `opt_sel`=0. `wake_hi` is ignored outside stop. `wake_lo` never causes any action or state change.
- R9: Simultaneous events give at most one of `rst_req`, `isr_req` and `cont_req`, chosen in the priority reset, then ISR, then continue. `stop_rel` is raised if any one of the events releases stop.
- R10: Action pulses last one cycle. A `stop_rel` pulse, or an `rst_req` pulse, rises on the same edge on which `in_stop` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_sel | input | 1 | Static policy column select |
| stop_req | input | 1 | Request to enter the stop state |
| ev_pin_rst | input | 1 | External reset pin event |
| ev_wdt | input | 1 | Watchdog timeout event |
| ev_por | input | 1 | Power-on-reset detector event |
| ev_lvd | input | 1 | Low-voltage detector event |
| ev_xint | input | 1 | External interrupt event |
| xint_en | input | 1 | Interrupts enabled status |
| wake_hi | input | N_HI | Wake pins that may release stop |
| wake_lo | input | N_LO | Wake pins that never release stop |
| rst_req | output | 1 | Chip reset request pulse |
| isr_req | output | 1 | External ISR entry pulse |
| cont_req | output | 1 | Continue-execution pulse |
| stop_rel | output | 1 | Stop-release pulse |
| in_stop | output | 1 | Stop-state flag |

## Verification
Each source is first fired alone in the normal state and then in the stop state, once for each value of `opt_sel`. This shows whether the option column and the mode are both taken into account. Firing `ev_xint` with `xint_en` at both values separates the ISR outcome from the continue and ignored outcomes. A long stretch of random multi-source cycles, with stop entries mixed in, is compared every clock against a behavioural model. That stretch exposes priority and release-merging mistakes, and it catches a stop entry that wrongly survives a reset in the same cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CONT = 2'd1,
    ACT_ISR  = 2'd2,
    ACT_RST  = 2'd3
  } act_e;

  localparam int SRC_PIN     = 0;
  localparam int SRC_WDT     = 1;
  localparam int SRC_POR     = 2;
  localparam int SRC_LVD     = 3;
  localparam int SRC_XINT    = 4;
  localparam int SRC_WAKE_HI = 5;
  localparam int SRC_WAKE_LO = 6;
  localparam int NSRC        = 7;
endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
  import wpc_pkg::*;
#(
  parameter int KIND = 0
) (
  input  logic in_stop,
  input  logic opt_sel,
  input  logic fire,
  input  logic xint_en,
  output act_e act,
  output logic rel
);
  always_comb begin
    act = ACT_NONE;
    rel = 1'b0;
    if (fire) begin
      case (KIND)
        SRC_PIN: act = ACT_RST;
        SRC_WDT: if (!in_stop) act = ACT_RST;
        SRC_POR: begin
          if (!in_stop) act = ACT_CONT;
          else if (!opt_sel) begin act = ACT_RST; rel = 1'b1; end
        end
        SRC_LVD: begin
          if (!in_stop) act = ACT_RST;
          else if (opt_sel) begin act = ACT_RST; rel = 1'b1; end
        end
        SRC_XINT: begin
          if (!in_stop) act = xint_en ? ACT_ISR : ACT_CONT;
          else if (xint_en) begin
            act = opt_sel ? ACT_ISR : ACT_RST;
            rel = 1'b1;
          end
        end
        SRC_WAKE_HI: begin
          if (in_stop) begin
            act = opt_sel ? ACT_CONT : ACT_RST;
            rel = 1'b1;
          end
        end
        default: act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wpc_resolve.sv
module wpc_resolve
  import wpc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  act_e       acts [N],
  input  logic [N-1:0] rels,
  output act_e       win,
  output logic       rel_any
);
  always_comb begin
    win = ACT_NONE;
    for (int i = 0; i < N; i++) begin
      if (acts[i] > win) win = acts[i];
    end
    rel_any = |rels;
  end
endmodule

// File: rtl/wake_policy_ctrl.sv
module wake_policy_ctrl
  import wpc_pkg::*;
#(
  parameter int N_HI = 8,
  parameter int N_LO = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            opt_sel,
  input  logic            stop_req,
  input  logic            ev_pin_rst,
  input  logic            ev_wdt,
  input  logic            ev_por,
  input  logic            ev_lvd,
  input  logic            ev_xint,
  input  logic            xint_en,
  input  logic [N_HI-1:0] wake_hi,
  input  logic [N_LO-1:0] wake_lo,
  output logic            rst_req,
  output logic            isr_req,
  output logic            cont_req,
  output logic            stop_rel,
  output logic            in_stop
);
  logic [NSRC-1:0] fire;
  logic [NSRC-1:0] rels;
  act_e            acts [NSRC];
  act_e            win;
  logic            rel_any;

  always_comb begin
    fire              = '0;
    fire[SRC_PIN]     = ev_pin_rst;
    fire[SRC_WDT]     = ev_wdt;
    fire[SRC_POR]     = ev_por;
    fire[SRC_LVD]     = ev_lvd;
    fire[SRC_XINT]    = ev_xint;
    fire[SRC_WAKE_HI] = |wake_hi;
    fire[SRC_WAKE_LO] = |wake_lo;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    wpc_decode #(.KIND(g)) u_dec (
      .in_stop (in_stop),
      .opt_sel (opt_sel),
      .fire    (fire[g]),
      .xint_en (xint_en),
      .act     (acts[g]),
      .rel     (rels[g])
    );
  end

  wpc_resolve #(.N(NSRC)) u_res (
    .acts    (acts),
    .rels    (rels),
    .win     (win),
    .rel_any (rel_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      isr_req  <= 1'b0;
      cont_req <= 1'b0;
      stop_rel <= 1'b0;
      in_stop  <= 1'b0;
    end else begin
      rst_req  <= (win == ACT_RST);
      isr_req  <= (win == ACT_ISR);
      cont_req <= (win == ACT_CONT);
      stop_rel <= rel_any;
      if (win == ACT_RST || rel_any) in_stop <= 1'b0;
      else if (!in_stop && stop_req) in_stop <= 1'b1;
    end
  end

  assert_one_action_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_req, isr_req, cont_req}));

  assert_rel_clears_R10: assert property (@(posedge clk) disable iff (rst)
    stop_rel |-> (!in_stop && $past(in_stop)));

  assert_rst_clears_R10: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !in_stop);

  assert_pin_reset_R3: assert property (@(posedge clk) disable iff (rst)
    ev_pin_rst |=> rst_req);

  assert_wdt_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (in_stop && fire == (NSRC'(1) << SRC_WDT)) |=> (in_stop && !rst_req && !stop_rel));

  assert_lo_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (in_stop && fire == (NSRC'(1) << SRC_WAKE_LO)) |=> (in_stop && !stop_rel && !cont_req));

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_stop && stop_req && fire == '0) |=> in_stop);
endmodule

// File: tb/test_wake_policy_ctrl.sv
module test_wake_policy_ctrl;
  localparam int N_HI = 8;
  localparam int N_LO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opt_sel = 1'b0, stop_req = 1'b0, ev_pin_rst = 1'b0, ev_wdt = 1'b0;
  logic ev_por = 1'b0, ev_lvd = 1'b0, ev_xint = 1'b0, xint_en = 1'b0;
  logic [N_HI-1:0] wake_hi = '0;
  logic [N_LO-1:0] wake_lo = '0;
  logic rst_req, isr_req, cont_req, stop_rel, in_stop;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_tag = "R1";

  bit m_stop = 0, e_rst = 0, e_isr = 0, e_cont = 0, e_rel = 0;

  always #4 clk = ~clk;

  wake_policy_ctrl #(.N_HI(N_HI), .N_LO(N_LO)) i_wake_policy_ctrl (
    .clk(clk), .rst(rst), .opt_sel(opt_sel), .stop_req(stop_req),
    .ev_pin_rst(ev_pin_rst), .ev_wdt(ev_wdt), .ev_por(ev_por), .ev_lvd(ev_lvd),
    .ev_xint(ev_xint), .xint_en(xint_en), .wake_hi(wake_hi), .wake_lo(wake_lo),
    .rst_req(rst_req), .isr_req(isr_req), .cont_req(cont_req),
    .stop_rel(stop_rel), .in_stop(in_stop)
  );

  // Behavioural reference: rank 3 reset, 2 ISR, 1 continue, 0 nothing
  always @(posedge clk) begin
    int best;
    bit rel;
    cycles++;
    best = 0;
    rel = 0;
    if (rst) begin
      m_stop = 0;
    end else begin
      if (!m_stop) begin
        if (ev_pin_rst || ev_wdt || ev_lvd) best = 3;
        else if (ev_xint && xint_en) best = 2;
        else if (ev_por || (ev_xint && !xint_en)) best = 1;
      end else begin
        if (ev_pin_rst) best = 3;
        if (opt_sel) begin
          if (ev_lvd) begin best = 3; rel = 1; end
          if (ev_xint && xint_en) begin rel = 1; if (best < 2) best = 2; end
          if (wake_hi != 0) begin rel = 1; if (best < 1) best = 1; end
        end else if (ev_por || (ev_xint && xint_en) || wake_hi != 0) begin
          best = 3;
          rel = 1;
        end
      end
      if (best == 3 || rel) m_stop = 0;
      else if (!m_stop && stop_req) m_stop = 1;
    end
    e_rst  = (best == 3);
    e_isr  = (best == 2);
    e_cont = (best == 1);
    e_rel  = rel;
  end

  task automatic cmp(string name, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", cur_tag, name, act, exp, cycles);
    end
  endtask

  task automatic clear_in();
    stop_req = 0; ev_pin_rst = 0; ev_wdt = 0; ev_por = 0; ev_lvd = 0;
    ev_xint = 0; xint_en = 0; wake_hi = '0; wake_lo = '0;
  endtask

  task automatic run(string t);
    cur_tag = t;
    @(negedge clk);
    cmp("rst_req", rst_req, e_rst);
    cmp("isr_req", isr_req, e_isr);
    cmp("cont_req", cont_req, e_cont);
    cmp("stop_rel", stop_rel, e_rel);
    cmp("in_stop", in_stop, m_stop);
    clear_in();
  endtask

  task automatic fire_src(int k);
    case (k)
      0: ev_pin_rst = 1;
      1: ev_wdt = 1;
      2: ev_por = 1;
      3: ev_lvd = 1;
      4: begin ev_xint = 1; xint_en = 1; end
      5: begin ev_xint = 1; xint_en = 0; end
      6: wake_hi = 8'h10;
      default: wake_lo = 4'h2;
    endcase
  endtask

  function automatic string src_tag(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    run("R1");
    run("R1");
    rst = 0;
    run("R1");
    run("R1");

    for (int o = 0; o < 2; o++) begin
      opt_sel = o[0];
      run("R1");
      for (int k = 0; k < 8; k++) begin
        opt_sel = o[0];
        fire_src(k);
        run(src_tag(k));
        run("R10");
        opt_sel = o[0];
        stop_req = 1;
        run("R2");
        opt_sel = o[0];
        stop_req = 1;
        run("R2");
        opt_sel = o[0];
        fire_src(k);
        run(src_tag(k));
        run("R10");
        opt_sel = o[0];
        ev_pin_rst = 1;
        run("R3");
        run("R10");
      end
    end

    opt_sel = 0;
    stop_req = 1; ev_lvd = 1;
    run("R2");
    ev_xint = 1; xint_en = 1; ev_por = 1;
    run("R9");
    ev_por = 1; ev_wdt = 1;
    run("R9");
    opt_sel = 1;
    stop_req = 1;
    run("R2");
    opt_sel = 1;
    ev_xint = 1; xint_en = 1; wake_hi = 8'h01;
    run("R9");
    opt_sel = 1;
    stop_req = 1;
    run("R2");
    opt_sel = 1;
    ev_pin_rst = 1; wake_hi = 8'h80;
    run("R9");

    for (int n = 0; n < 4000; n++) begin
      if ((n % 500) == 0) opt_sel = $urandom_range(0, 1);
      stop_req   = ($urandom_range(0, 3) == 0);
      ev_pin_rst = ($urandom_range(0, 40) == 0);
      ev_wdt     = ($urandom_range(0, 15) == 0);
      ev_por     = ($urandom_range(0, 15) == 0);
      ev_lvd     = ($urandom_range(0, 20) == 0);
      ev_xint    = ($urandom_range(0, 10) == 0);
      xint_en    = $urandom_range(0, 1);
      wake_hi    = ($urandom_range(0, 12) == 0) ? N_HI'($urandom) : '0;
      wake_lo    = ($urandom_range(0, 4) == 0) ? N_LO'($urandom) : '0;
      run("R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule